// File: doc/BRIEF.md
# Programmable Sum-Term Logic Array

A configurable combinational translator for one processor core. A 32-bit input word is fed through a programmable array of AND terms. Each output bit has its own 32-bit row of term enables. The bit is the OR of every input bit whose term enable is set. It can then be inverted per bit, and it is stored in a 32-bit output register.

Each output bit also has a write-enable. Bits whose enable is clear keep their old value. This lets several translations merge into separate fields of the same output word.

The configuration is held in registers and loaded one word at a time through a simple write port. There are thirty-four of these words: the per-bit write-enable word, the per-bit invert word, and one term row for each output bit. After loading, any fixed bit scatter, gather, permutation or OR-combination of the input can be applied in a single clock per word. Sizes are parameters; the defaults give 32 inputs and 32 outputs.

Top module: `sum_term_array`

## Requirements
- R1: While `rst_n` is low, at the next rising clock edge the output register and every configuration word (write-enable word, invert word, all term rows) become zero.
- R2: A configuration write (`cfg_we` high) loads `cfg_data` into the word chosen by `cfg_addr`. Address 0 is the per-bit write-enable word. Address 1 is the per-bit invert word. Address 2+n is the term row of output bit n, whose bit i enables input bit i.
- R3: On a translation (`xlate_en` high), each output bit n whose write-enable bit is 1 is loaded with the OR over i of (row n bit i AND `src_word` bit i), XORed with invert bit n.
- R4: On a translation, each output bit whose write-enable bit is 0 keeps its previous value.
- R5: The translation result is visible on `dst_word` right after the rising edge at which `xlate_en` is sampled high, one clock of latency.
- R6: A configuration write to any address above 2+OUT_W-1 (34 to 63 by default) changes no configuration word.
- R7: When a configuration write and a translation happen in the same cycle, the translation uses the configuration as it was before that write.
- R8: In a cycle with `xlate_en` low, `dst_word` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration word select (clog2(OUT_W+2)) |
| cfg_data | input | 32 | Configuration word value (max of IN_W, OUT_W) |
| xlate_en | input | 1 | Start a translation of `src_word` this cycle |
| src_word | input | 32 | Input word (IN_W) |
| dst_word | output | 32 | Output register (OUT_W) |

## Verification
Every result in this block is due exactly one rising edge after its cause. Configuration writes take effect at the edge at which they are sampled. A translation's output shows up on `dst_word` right after its own edge. The bench drives strobes and data on the falling edge and samples `dst_word` on the next falling edge, half a period after the result lands. So a same-cycle write and translation shows the old configuration, and the following translation shows the new one. A reference model in the bench tracks every write and translation, and each sample is compared against it. A fixed vector table walks the identity-with-inversion setup.

// File: rtl/ste_pkg.sv
package ste_pkg;

   // Configuration address map: order is decoded by the bank
   localparam int unsigned CFG_WMASK_ADDR = 0;
   localparam int unsigned CFG_INV_ADDR   = 1;
   localparam int unsigned CFG_ROW_BASE   = 2;

   function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic int unsigned addr_bits(input int unsigned outs);
      return (outs + CFG_ROW_BASE <= 2) ? 1 : $clog2(outs + CFG_ROW_BASE);
   endfunction

endpackage

// File: rtl/ste_cfg_bank.sv
module ste_cfg_bank
   import ste_pkg::*;
#(
   parameter int unsigned IN_W   = 32,
   parameter int unsigned OUT_W  = 32,
   parameter int unsigned ADDR_W = addr_bits(OUT_W),
   parameter int unsigned DATA_W = max_of(IN_W, OUT_W)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cfg_we,
   input  logic [ADDR_W-1:0]            cfg_addr,
   input  logic [DATA_W-1:0]            cfg_data,
   output logic [OUT_W-1:0]             wmask_q,
   output logic [OUT_W-1:0]             inv_q,
   output logic [OUT_W-1:0][IN_W-1:0]   rows_q
);

   logic sel_wmask;
   logic sel_inv;

   assign sel_wmask = cfg_we && (cfg_addr == ADDR_W'(CFG_WMASK_ADDR));
   assign sel_inv   = cfg_we && (cfg_addr == ADDR_W'(CFG_INV_ADDR));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wmask_q <= '0;
         inv_q   <= '0;
      end else begin
         if (sel_wmask) wmask_q <= cfg_data[OUT_W-1:0];
         if (sel_inv)   inv_q   <= cfg_data[OUT_W-1:0];
      end
   end

   for (genvar n = 0; n < OUT_W; n++) begin : g_row
      logic sel_row;
      assign sel_row = cfg_we && (cfg_addr == ADDR_W'(CFG_ROW_BASE + n));
      always_ff @(posedge clk) begin
         if (!rst_n)       rows_q[n] <= '0;
         else if (sel_row) rows_q[n] <= cfg_data[IN_W-1:0];
      end
   end

   // R2
   wmask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == ADDR_W'(CFG_WMASK_ADDR)) |=> (wmask_q == $past(cfg_data[OUT_W-1:0])));

   // R2
   row0_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == ADDR_W'(CFG_ROW_BASE)) |=> (rows_q[0] == $past(cfg_data[IN_W-1:0])));

   // R6
   bad_addr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && (int'(cfg_addr) >= int'(CFG_ROW_BASE + OUT_W)))
         |=> ($stable(wmask_q) && $stable(inv_q) && $stable(rows_q)));

   // R1
   cfg_reset_chk: assert property (@(posedge clk)
      (!rst_n) |=> (wmask_q == '0 && inv_q == '0 && rows_q == '0));

endmodule

// File: rtl/ste_term_row.sv
module ste_term_row #(
   parameter int unsigned IN_W = 32
) (
   input  logic [IN_W-1:0] row,
   input  logic [IN_W-1:0] src,
   input  logic            inv,
   output logic            term
);

   logic [IN_W-1:0] hits;

   assign hits = row & src;
   assign term = (|hits) ^ inv;

endmodule

// File: rtl/ste_out_reg.sv
module ste_out_reg #(
   parameter int unsigned OUT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             xlate_en,
   input  logic [OUT_W-1:0] wmask,
   input  logic [OUT_W-1:0] terms,
   output logic [OUT_W-1:0] dst_q
);

   always_ff @(posedge clk) begin
      if (!rst_n)        dst_q <= '0;
      else if (xlate_en) dst_q <= (terms & wmask) | (dst_q & ~wmask);
   end

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!xlate_en) |=> $stable(dst_q));

   // R4
   masked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xlate_en |=> ((dst_q & ~$past(wmask)) == ($past(dst_q) & ~$past(wmask))));

   // R1
   out_reset_chk: assert property (@(posedge clk)
      (!rst_n) |=> (dst_q == '0));

endmodule

// File: rtl/sum_term_array.sv
module sum_term_array
   import ste_pkg::*;
#(
   parameter int unsigned IN_W   = 32,
   parameter int unsigned OUT_W  = 32,
   parameter int unsigned ADDR_W = addr_bits(OUT_W),
   parameter int unsigned DATA_W = max_of(IN_W, OUT_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_data,
   input  logic              xlate_en,
   input  logic [IN_W-1:0]   src_word,
   output logic [OUT_W-1:0]  dst_word
);

   localparam int unsigned CFG_WORDS = OUT_W + CFG_ROW_BASE;

   if (IN_W < 1 || OUT_W < 1) begin : g_bad_size
      $error("sum_term_array: IN_W and OUT_W must be at least 1");
   end
   if ((1 << ADDR_W) < CFG_WORDS) begin : g_bad_addr
      $error("sum_term_array: ADDR_W too narrow for the configuration words");
   end
   if (DATA_W < IN_W || DATA_W < OUT_W) begin : g_bad_data
      $error("sum_term_array: DATA_W narrower than a configuration word");
   end

   logic [OUT_W-1:0]           wmask;
   logic [OUT_W-1:0]           inv;
   logic [OUT_W-1:0][IN_W-1:0] rows;
   logic [OUT_W-1:0]           terms;

   ste_cfg_bank #(
      .IN_W  (IN_W),
      .OUT_W (OUT_W),
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
   ) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_we  (cfg_we),
      .cfg_addr(cfg_addr),
      .cfg_data(cfg_data),
      .wmask_q (wmask),
      .inv_q   (inv),
      .rows_q  (rows)
   );

   for (genvar n = 0; n < OUT_W; n++) begin : g_term
      ste_term_row #(.IN_W(IN_W)) u_row (
         .row (rows[n]),
         .src (src_word),
         .inv (inv[n]),
         .term(terms[n])
      );
   end

   ste_out_reg #(.OUT_W(OUT_W)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .xlate_en(xlate_en),
      .wmask   (wmask),
      .terms   (terms),
      .dst_q   (dst_word)
   );

   // R3 R5 R7: enabled bits carry the terms formed from pre-edge configuration
   enabled_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xlate_en |=> ((dst_word & $past(wmask)) == ($past(terms) & $past(wmask))));

   // R3
   bit0_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xlate_en && wmask[0]) |=> (dst_word[0] == ($past(|(rows[0] & src_word)) ^ $past(inv[0]))));

endmodule

// File: tb/sum_term_array_bench.sv
module sum_term_array_bench;

   localparam int CLK_PERIOD = 10;
   localparam int W = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [5:0]    cfg_addr = '0;
   logic [W-1:0]  cfg_data = '0;
   logic          xlate_en = 1'b0;
   logic [W-1:0]  src_word = '0;
   logic [W-1:0]  dst_word;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   // bench reference state
   logic [W-1:0] m_wmask, m_inv, m_dst;
   logic [W-1:0] m_rows [W];

   always #(CLK_PERIOD/2) clk = ~clk;

   sum_term_array u_sum_term_array (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_data(cfg_data), .xlate_en(xlate_en), .src_word(src_word),
      .dst_word(dst_word)
   );

   // identity rows, upper half inverted, all bits writable
   localparam int NVEC = 5;
   localparam logic [W-1:0] VEC_SRC [NVEC] = '{32'h0000_0000, 32'hFFFF_FFFF,
      32'h1234_5678, 32'hA5A5_A5A5, 32'h8000_0001};
   localparam logic [W-1:0] VEC_EXP [NVEC] = '{32'hFFFF_0000, 32'h0000_FFFF,
      32'hEDCB_5678, 32'h5A5A_A5A5, 32'h7FFF_0001};

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: dst_word=%h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] model_terms(input logic [W-1:0] s);
      logic [W-1:0] t;
      for (int n = 0; n < W; n++) t[n] = (|(m_rows[n] & s)) ^ m_inv[n];
      return t;
   endfunction

   task automatic model_reset();
      m_wmask = '0; m_inv = '0; m_dst = '0;
      for (int n = 0; n < W; n++) m_rows[n] = '0;
   endtask

   // one clock: drive on falling edge, result sampled at next falling edge
   task automatic cycle(input bit we, input int addr, input logic [W-1:0] data,
                        input bit xl, input logic [W-1:0] s);
      logic [W-1:0] t;
      @(negedge clk);
      cfg_we = we; cfg_addr = 6'(addr); cfg_data = data; xlate_en = xl; src_word = s;
      t = model_terms(s);               // old configuration (R7)
      if (xl) m_dst = (t & m_wmask) | (m_dst & ~m_wmask);
      if (we) begin
         if (addr == 0) m_wmask = data;
         else if (addr == 1) m_inv = data;
         else if (addr >= 2 && addr < 2 + W) m_rows[addr-2] = data;
      end
      @(negedge clk);
      cfg_we = 1'b0; xlate_en = 1'b0;
   endtask

   task automatic write_cfg(input int addr, input logic [W-1:0] data);
      cycle(1'b1, addr, data, 1'b0, '0);
   endtask

   task automatic xlate(input logic [W-1:0] s);
      cycle(1'b0, 0, '0, 1'b1, s);
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      model_reset();
      rst_n = 1'b1;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: dst_word=%h expected run to complete", dst_word);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      model_reset();
      do_reset();
      check("R1 reset output", dst_word, 32'h0);
      // R1: config cleared, so a translation writes nothing
      xlate(32'hFFFF_FFFF);
      check("R1 reset config", dst_word, 32'h0);

      // R2: load identity configuration
      write_cfg(0, 32'hFFFF_FFFF);
      write_cfg(1, 32'hFFFF_0000);
      for (int n = 0; n < W; n++) write_cfg(2 + n, 32'(1) << n);

      // R3 R5: vector table
      for (int v = 0; v < NVEC; v++) begin
         xlate(VEC_SRC[v]);
         check("R3 R5 table", dst_word, VEC_EXP[v]);
         check("R3 model", dst_word, m_dst);
      end

      // R8: idle cycles keep the output
      cycle(1'b0, 0, '0, 1'b0, 32'h1357_9BDF);
      check("R8 idle hold", dst_word, VEC_EXP[NVEC-1]);

      // R3: OR over several terms: row 0 picks bits 31 and 4
      write_cfg(2, 32'h8000_0010);
      xlate(32'h8000_0000);
      check("R3 multi-term OR", dst_word, m_dst);
      check("R3 bit0 set", {31'h0, dst_word[0]}, 32'h1);
      xlate(32'h0000_0000);
      check("R3 bit0 clear", {31'h0, dst_word[0]}, 32'h0);

      // R4: only low half writable; upper keeps 0xFFFF from last word
      write_cfg(0, 32'h0000_FFFF);
      xlate(32'hFFFF_FFFF);
      check("R4 masked hold", dst_word, 32'hFFFF_FFFF);
      check("R4 model", dst_word, m_dst);

      // R6: writes above row range ignored (would alter rows/masks if aliased)
      write_cfg(34, 32'h0000_0000);
      write_cfg(63, 32'h0000_0000);
      write_cfg(0, 32'hFFFF_FFFF);
      xlate(32'h0000_0000);
      check("R6 ignored address", dst_word, 32'hFFFF_0000);
      check("R6 model", dst_word, m_dst);

      // R2: address 1 is the invert word
      write_cfg(1, 32'h0000_00FF);
      xlate(32'h0000_0000);
      check("R2 invert address", dst_word, 32'h0000_00FF);

      // R7: same-cycle write of row 5 to zero with translation uses old row
      cycle(1'b1, 7, 32'h0, 1'b1, 32'h0000_0020);
      check("R7 old config", dst_word, 32'h0000_00DF);
      xlate(32'h0000_0020);
      check("R7 new config", dst_word, 32'h0000_00FF);
      check("R7 model", dst_word, m_dst);

      // R1: reset in the middle clears output and all configuration
      do_reset();
      check("R1 mid-run reset", dst_word, 32'h0);
      write_cfg(0, 32'hFFFF_FFFF);
      xlate(32'hFFFF_FFFF);
      check("R1 rows and invert cleared", dst_word, 32'h0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule